// File: doc/BRIEF.md
# Sector Page Refresh Scheduler

The scheduler sits on the host side of a serial flash that has three sectors of unequal size. It watches page erase/program events, each carrying a 9-bit page address. For each event it starts one refresh cycle in the sector that the event touched. A refresh cycle has two steps. The first is a page-to-buffer transfer request (opcode 53h). The second is an automatic page rewrite request (opcode 58h). Both steps target the page that the sector's rotating pointer selects.

After each request the block waits for a status report whose ready bit is set. It then takes the next step. When the rewrite completes, the pointer moves to the next page of the sector and wraps at the sector's end. Because the pointer rotates, every page of a sector is rewritten within a bounded number of operations. A per-sector operation counter enforces this bound. The counter raises a sticky error bit if a full rotation does not finish within `LIMIT` operations.

Requests leave on a valid/ready handshake as an opcode plus a page number. Only one request is outstanding at a time. New write events are held off from the moment an event is accepted until its rewrite completes. The SPI transaction engine is outside the block. That engine performs the requests and the status polls, and it returns each poll result as `stat_valid` with `stat_rdy`, which carries status bit 7.

The controller is a five-state machine with the following transitions:
- **IDLE to XFER_REQ**: taken when a write event is accepted.
- **XFER_REQ to XFER_POLL**: taken when the transfer request is accepted.
- **XFER_POLL to RW_REQ**: taken when a ready status arrives.
- **RW_REQ to RW_POLL**: taken when the rewrite request is accepted.
- **RW_POLL to IDLE**: taken when a ready status arrives. This transition also advances the sector's pointer.

Top module: `sector_refresh_sched`

## Requirements
- R1: Sectors are decoded from the page address as follows. Sector 0 is pages 0 to 7, where bits 8..3 are all zero. Sector 1 is pages 8 to 255, where bit 8 is 0 and bits 7..3 are nonzero. Sector 2 is pages 256 to 511, where bit 8 is 1. Sector i drives `sect_err[i]`.
- R2: `wr_ready` is high only in IDLE. A write event is accepted on a cycle where both `wr_valid` and `wr_ready` are high. `wr_valid` has no effect while `wr_ready` is low.
- R3: In the cycle after a write event is accepted, `req_valid` rises with `req_opcode` = 8'h53. `req_page` equals the current pointer of the written page's sector.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_opcode` and `req_page` hold their values.
- R5: After a request is accepted, no new request is issued until a status report arrives with `stat_valid`=1 and `stat_rdy`=1. A report with `stat_rdy`=0 leaves the block waiting.
- R6: After the transfer completes, a request with `req_opcode` = 8'h58 is issued for the same page. The block then waits for a ready status again before it returns to IDLE.
- R7: When the rewrite completes, the pointer of that sector advances by one. The pointer wraps from the sector's last page to its first page. Each sector's pointer is independent of the others, and after reset each pointer holds its sector's first page.
- R8: A sector's operation count rises by one for each accepted write event and for each completed rewrite. Transfers do not add to the count. The count clears when that sector's pointer wraps.
- R9: `sect_err[i]` becomes 1 once sector i's count reaches `LIMIT`, and stays 1 until reset.
- R10: During and after reset, `wr_ready`=1, `req_valid`=0 and `sect_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Page erase/program event present |
| wr_page | input | 9 | Page address of the event |
| wr_ready | output | 1 | Event accepted this cycle if valid |
| req_valid | output | 1 | Request to the SPI engine pending |
| req_opcode | output | 8 | 53h transfer or 58h rewrite |
| req_page | output | 9 | Page for the request |
| req_ready | input | 1 | SPI engine takes the request |
| stat_valid | input | 1 | A status poll result is present |
| stat_rdy | input | 1 | Ready bit (status bit 7) of that poll |
| sect_err | output | 3 | Sticky per-sector overrun flags |

## Verification
The bench uses pages at each sector boundary: 7, 8, 255, 256 and 511. A wrong decode at any of these would send the refresh into the wrong sector's pointer range. It feeds busy status reports and holds `req_ready` low for extra cycles. A design that advanced on any status report, or that changed the request while it was stalled, would show the wrong opcode or page early. It keeps `wr_valid` asserted through a whole refresh. A design that accepted that extra event would shift the later pointer sequence and counts. It runs sector 0 through three wraps, which is more than `LIMIT` operations in total, so a counter that never clears would raise a false error. It also drives sector 1 past `LIMIT`, so that a missing or non-sticky error bit is exposed.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int PAGE_W  = 9;
    localparam int NUM_SEC = 3;
    localparam int SEC_W   = 2;

    localparam logic [7:0] OP_XFER    = 8'h53;
    localparam logic [7:0] OP_REWRITE = 8'h58;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER_REQ,
        ST_XFER_POLL,
        ST_RW_REQ,
        ST_RW_POLL
    } rfs_state_e;

    function automatic logic [SEC_W-1:0] sector_of(input logic [PAGE_W-1:0] pg);
        if (pg[8])             return 2'd2;
        else if (pg[7:3] != 0) return 2'd1;
        else                   return 2'd0;
    endfunction

    function automatic logic [PAGE_W-1:0] sec_first(input int s);
        case (s)
            0:       return 9'd0;
            1:       return 9'd8;
            default: return 9'd256;
        endcase
    endfunction

    function automatic logic [PAGE_W-1:0] sec_last(input int s);
        case (s)
            0:       return 9'd7;
            1:       return 9'd255;
            default: return 9'd511;
        endcase
    endfunction
endpackage

// File: rtl/rfs_sector.sv
module rfs_sector
    import rfs_pkg::*;
#(
    parameter int               LIMIT = 10000,
    parameter logic [PAGE_W-1:0] FIRST = '0,
    parameter logic [PAGE_W-1:0] LAST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_op,
    input  logic              rotate,
    output logic [PAGE_W-1:0] ptr,
    output logic              err
);
    localparam int            CW    = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= FIRST;
            cnt <= '0;
            err <= 1'b0;
        end else begin
            if (rotate) begin
                if (ptr == LAST) begin
                    ptr <= FIRST;
                    cnt <= '0;
                end else begin
                    ptr <= ptr + 1'b1;
                    if (cnt < LIM_C) cnt <= cnt + 1'b1;
                end
            end else if (add_op && cnt < LIM_C) begin
                cnt <= cnt + 1'b1;
            end
            if (cnt == LIM_C) err <= 1'b1;
        end
    end
endmodule

// File: rtl/rfs_fsm.sv
module rfs_fsm
    import rfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic req_ready,
    input  logic stat_valid,
    input  logic stat_rdy,
    output logic wr_ready,
    output logic accept,
    output logic req_valid,
    output logic is_rewrite,
    output logic rw_done
);
    rfs_state_e state, nxt;
    logic       stat_ok;

    assign stat_ok = stat_valid && stat_rdy;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (wr_valid)  nxt = ST_XFER_REQ;
            ST_XFER_REQ:  if (req_ready) nxt = ST_XFER_POLL;
            ST_XFER_POLL: if (stat_ok)   nxt = ST_RW_REQ;
            ST_RW_REQ:    if (req_ready) nxt = ST_RW_POLL;
            ST_RW_POLL:   if (stat_ok)   nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_ready   = (state == ST_IDLE);
        accept     = wr_ready && wr_valid;
        req_valid  = (state == ST_XFER_REQ) || (state == ST_RW_REQ);
        is_rewrite = (state == ST_RW_REQ);
        rw_done    = (state == ST_RW_POLL) && stat_ok;
    end
endmodule

// File: rtl/sector_refresh_sched.sv
module sector_refresh_sched
    import rfs_pkg::*;
#(
    parameter int LIMIT = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [PAGE_W-1:0] wr_page,
    output logic              wr_ready,
    output logic              req_valid,
    output logic [7:0]        req_opcode,
    output logic [PAGE_W-1:0] req_page,
    input  logic              req_ready,
    input  logic              stat_valid,
    input  logic              stat_rdy,
    output logic [NUM_SEC-1:0] sect_err
);
    logic              accept, is_rewrite, rw_done;
    logic [SEC_W-1:0]  wr_sec, cur_sec;
    logic [PAGE_W-1:0] ptr_arr [NUM_SEC];
    logic [PAGE_W-1:0] tgt_page;

    assign wr_sec = sector_of(wr_page);

    rfs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .req_ready  (req_ready),
        .stat_valid (stat_valid),
        .stat_rdy   (stat_rdy),
        .wr_ready   (wr_ready),
        .accept     (accept),
        .req_valid  (req_valid),
        .is_rewrite (is_rewrite),
        .rw_done    (rw_done)
    );

    for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
        rfs_sector #(
            .LIMIT (LIMIT),
            .FIRST (sec_first(g)),
            .LAST  (sec_last(g))
        ) u_sec (
            .clk    (clk),
            .rst_n  (rst_n),
            .add_op (accept && (wr_sec == SEC_W'(g))),
            .rotate (rw_done && (cur_sec == SEC_W'(g))),
            .ptr    (ptr_arr[g]),
            .err    (sect_err[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_sec  <= '0;
            tgt_page <= '0;
        end else if (accept) begin
            cur_sec  <= wr_sec;
            tgt_page <= ptr_arr[wr_sec];
        end
    end

    assign req_opcode = is_rewrite ? OP_REWRITE : OP_XFER;
    assign req_page   = tgt_page;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_ready,
    input logic       req_valid,
    input logic [7:0] req_opcode,
    input logic [8:0] req_page,
    input logic       req_ready,
    input logic [2:0] sect_err
);
    AST_NO_WRITE_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !wr_ready); // R2

    AST_LEGAL_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_opcode == 8'h53 || req_opcode == 8'h58)); // R3

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_opcode) && $stable(req_page)); // R4

    AST_WAIT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R5

    AST_XFER_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_opcode == 8'h53 |=> !wr_ready); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_err & $past(sect_err)) == $past(sect_err)); // R9
endmodule

bind sector_refresh_sched rfs_checker u_rfs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .req_valid  (req_valid),
    .req_opcode (req_opcode),
    .req_page   (req_page),
    .req_ready  (req_ready),
    .sect_err   (sect_err)
);

// File: tb/tb_sector_refresh_sched.sv
module tb_sector_refresh_sched;
    localparam int LIM = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_page = '0;
    logic       wr_ready;
    logic       req_valid;
    logic [7:0] req_opcode;
    logic [8:0] req_page;
    logic       req_ready = 1'b0;
    logic       stat_valid = 1'b0;
    logic       stat_rdy = 1'b0;
    logic [2:0] sect_err;

    int checks = 0;
    int fails  = 0;

    int mptr [3];
    int mcnt [3];
    logic [2:0] merr;
    int first_pg [3] = '{0, 8, 256};
    int last_pg  [3] = '{7, 255, 511};

    always #10 clk = ~clk;

    sector_refresh_sched #(.LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_page(wr_page),
        .wr_ready(wr_ready), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_page(req_page), .req_ready(req_ready), .stat_valid(stat_valid),
        .stat_rdy(stat_rdy), .sect_err(sect_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sec_model(input int pg);
        if (pg >= 256) return 2;
        if (pg >= 8)   return 1;
        return 0;
    endfunction

    task automatic bump(input int s);
        if (mcnt[s] < LIM) mcnt[s]++;
        if (mcnt[s] >= LIM) merr[s] = 1'b1;
    endtask

    // One complete refresh cycle for a write to page pg; hold_wr keeps wr_valid high meanwhile.
    task automatic do_write(input int pg, input bit hold_wr);
        int s = sec_model(pg);
        int exp_pg = mptr[s];
        @(negedge clk);
        wr_valid = 1'b1;
        wr_page  = 9'(pg);
        @(negedge clk);
        if (!hold_wr) wr_valid = 1'b0;
        bump(s);
        // R3: transfer request for the sector pointer page
        check(req_valid == 1'b1, "R3 req_valid", req_valid, 1);
        check(req_opcode == 8'h53, "R3 opcode", req_opcode, 8'h53);
        check(req_page == 9'(exp_pg), "R1 R3 page", req_page, exp_pg);
        check(wr_ready == 1'b0, "R2 stall", wr_ready, 0);
        // R4: stall one cycle
        @(negedge clk);
        check(req_valid && req_opcode == 8'h53 && req_page == 9'(exp_pg), "R4 hold", req_page, exp_pg);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        // R5: busy report is not completion
        stat_valid = 1'b1;
        stat_rdy   = 1'b0;
        @(negedge clk);
        check(req_valid == 1'b0, "R5 busy wait", req_valid, 0);
        check(wr_ready == 1'b0, "R2 stall poll", wr_ready, 0);
        stat_rdy = 1'b1;
        @(negedge clk);
        stat_valid = 1'b0;
        stat_rdy   = 1'b0;
        // R6: rewrite request, same page
        check(req_valid && req_opcode == 8'h58, "R6 opcode", req_opcode, 8'h58);
        check(req_page == 9'(exp_pg), "R6 page", req_page, exp_pg);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        check(req_valid == 1'b0, "R5 rewrite wait", req_valid, 0);
        check(wr_ready == 1'b0, "R2 stall rewrite", wr_ready, 0);
        wr_valid   = 1'b0;
        stat_valid = 1'b1;
        stat_rdy   = 1'b1;
        @(negedge clk);
        stat_valid = 1'b0;
        stat_rdy   = 1'b0;
        if (mptr[s] == last_pg[s]) begin
            mptr[s] = first_pg[s];
            mcnt[s] = 0;
        end else begin
            mptr[s]++;
            bump(s);
        end
        @(negedge clk);
        check(wr_ready == 1'b1, "R2 back to idle", wr_ready, 1);
        check(sect_err == merr, "R8 R9 err", sect_err, merr);
    endtask

    task automatic t_reset;
        check(wr_ready == 1'b1, "R10 wr_ready", wr_ready, 1);
        check(req_valid == 1'b0, "R10 req_valid", req_valid, 0);
        check(sect_err == 3'b000, "R10 sect_err", sect_err, 0);
    endtask

    task automatic t_independent;
        // R7: separate pointers start at each sector's first page
        do_write(3, 1'b0);
        do_write(100, 1'b0);
        do_write(300, 1'b0);
        do_write(5, 1'b0);
        check(mptr[0] == 2, "R7 model", mptr[0], 2);
    endtask

    task automatic t_boundaries;
        // R1: edge pages; hold wr_valid during one to show R2 ignore
        do_write(7, 1'b1);
        do_write(8, 1'b0);
        do_write(255, 1'b1);
        do_write(256, 1'b0);
        do_write(511, 1'b0);
    endtask

    task automatic t_wrap;
        // R7 R8: three rotations of sector 0 (48 ops > LIMIT) with no error
        for (int i = 0; i < 24; i++) do_write(i % 8, 1'b0);
        check(sect_err[0] == 1'b0, "R8 wrap clears count", sect_err[0], 0);
    endtask

    task automatic t_overrun;
        // R9: sector 1 cannot finish a rotation within LIMIT ops
        for (int i = 0; i < 20; i++) do_write(9 + i, 1'b0);
        check(sect_err[1] == 1'b1, "R9 err set", sect_err[1], 1);
        do_write(0, 1'b0);
        check(sect_err[1] == 1'b1, "R9 err sticky", sect_err[1], 1);
        check(sect_err[2] == 1'b0, "R9 other sector clear", sect_err[2], 0);
    endtask

    initial begin
        for (int s = 0; s < 3; s++) begin
            mptr[s] = first_pg[s];
            mcnt[s] = 0;
        end
        merr = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_independent();
        t_boundaries();
        t_wrap();
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule